// File: doc/BRIEF.md
# I2C Configuration Register Slave

This block lets an I2C master program a bank of 8-bit configuration registers. After addressing the device, the master sends a pointer byte followed by any number of data bytes, which land in consecutive registers. To read, the master sets the pointer and then issues a read frame, either after a STOP and a fresh START or through a repeated START. The pointer advances by one after every byte transferred, in either direction, and keeps its value from one frame to the next.

Two single-byte command frames copy the whole bank to a non-volatile store or reload the bank from it. The copy starts after the master's STOP. Until the copy completes, the slave refuses its own address. When reset is released, a reload runs by itself, so the bank comes up holding the stored contents. During any reload, `out_disable` is held high so that the clock outputs fed from this bank stay off.

The store is reached through a request port using valid/ready. A request (`nv_valid` with `nv_write`, `nv_addr`, `nv_wdata`) is held stable until the cycle in which `nv_ready` is high. A read request is answered later by a one-cycle `nv_rvalid` pulse carrying `nv_rdata`. The response cannot be back-pressured, and only one read is outstanding at any time.

Top module: `cfg_i2c_slave`

## Requirements
- R1: The slave acknowledges only the 7-bit address 0x6A (address byte 0xD4 to write, 0xD5 to read). Any other address gets no acknowledge and changes no register.
- R2: In a write frame, the first data byte loads the pointer. Each later byte is stored at the pointer, and the pointer then increments. Every data byte is acknowledged.
- R3: A read frame returns the register at the pointer and increments the pointer after each byte. It works after a STOP and new START, and also after a repeated START. The pointer carries over between frames.
- R4: With the default of 16 registers, a pointer of 16 or more reads back as 0x00, and writes at such a pointer leave every register unchanged.
- R5: A write frame whose only data byte is 0xA5 saves the bank once STOP is seen. The store receives register i at `nv_addr` = i, for every register.
- R6: A write frame whose only data byte is 0xC3 reloads the bank after STOP. Register i is taken from store address i.
- R7: While a save or reload is running, the address byte gets no acknowledge. Once the operation ends, the address is acknowledged again.
- R8: After reset, a reload runs before any frame is acknowledged. `out_disable` is 1 during every reload and 0 at all other times, including during a save.
- R9: A command code followed by a further data byte in the same frame is an ordinary pointer-and-data write, and it starts no store operation.
- R10: A store request stays unchanged while `nv_ready` is low. A save issues exactly one write per register.
- R11: Register i appears on `cfg_q[8*i+7:8*i]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | I2C clock line as seen at the pad |
| sda_i | input | 1 | I2C data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls the data line low (open drain) |
| nv_valid | output | 1 | Store request valid |
| nv_ready | input | 1 | Store accepts the request this cycle |
| nv_write | output | 1 | 1 for a write request, 0 for a read request |
| nv_addr | output | 4 | Store word address (register index) |
| nv_wdata | output | 8 | Store write data |
| nv_rvalid | input | 1 | Read data valid pulse |
| nv_rdata | input | 8 | Read data from the store |
| cfg_q | output | 128 | Flattened register bank |
| out_disable | output | 1 | High while a reload is running |

## Verification
The hardest behaviour to reach from the ports is the refused address during a save or reload. A working store finishes a copy of 16 words long before an address byte at bus speed can arrive. To open that window, the bench stalls its store model by holding `nv_ready` low. It issues the command, checks for a missing acknowledge and for the correct level of `out_disable`, and then releases the stall. Power-up is reached the same way, with the store stalled from reset. Random pointer and data bursts, some of which cross the end of the bank, run against a register model in the bench.

// File: rtl/cfg_i2c_pkg.sv
package cfg_i2c_pkg;
  localparam int BYTE_W = 8;
  localparam logic [6:0] DEV_ADDR_DEF = 7'h6A;
  localparam logic [7:0] CODE_SAVE = 8'hA5;
  localparam logic [7:0] CODE_RELOAD = 8'hC3;

  typedef enum logic [2:0] {
    T_IDLE, T_ADDR, T_ACK, T_WR, T_RD, T_MACK
  } tgt_state_e;

  typedef enum logic [1:0] {
    N_IDLE, N_SAVE, N_RLD_REQ, N_RLD_WAIT
  } nv_state_e;
endpackage

// File: rtl/i2c_line_cond.sv
module i2c_line_cond #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES:0] scl_p, sda_p;
  logic scl_s, scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= '1;
      sda_p <= '1;
    end else begin
      scl_p <= {scl_p[STAGES-1:0], scl_i};
      sda_p <= {sda_p[STAGES-1:0], sda_i};
    end
  end

  assign scl_s = scl_p[STAGES-1];
  assign scl_q = scl_p[STAGES];
  assign sda_s = sda_p[STAGES-1];
  assign sda_q = sda_p[STAGES];

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_target_fsm.sv
module i2c_target_fsm
  import cfg_i2c_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter logic [6:0] DEV_ADDR = DEV_ADDR_DEF,
  parameter logic [7:0] SAVE_CODE = CODE_SAVE,
  parameter logic [7:0] RELOAD_CODE = CODE_RELOAD
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_det,
  input  logic       stop_det,
  input  logic       busy,
  input  logic [7:0] rd_data,
  output logic [7:0] ptr,
  output logic       sda_oe,
  output logic       wr_en,
  output logic [7:0] wr_addr,
  output logic [7:0] wr_data,
  output logic       cmd_save,
  output logic       cmd_reload
);
  tgt_state_e st;
  logic [3:0] cnt;
  logic [7:0] rxsh, txsh, last_byte;
  logic [1:0] nbytes;
  logic rw, ours, mnack;
  logic in_bank;

  assign in_bank = ({1'b0, ptr} < 9'(NUM_REGS));
  assign sda_oe  = (st == T_ACK) || ((st == T_RD) && !txsh[7]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= T_IDLE;
      cnt <= '0;
      rxsh <= '0;
      txsh <= '1;
      last_byte <= '0;
      nbytes <= '0;
      rw <= 1'b0;
      ours <= 1'b0;
      mnack <= 1'b0;
      ptr <= '0;
      wr_en <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
      cmd_save <= 1'b0;
      cmd_reload <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      cmd_save <= 1'b0;
      cmd_reload <= 1'b0;
      if (start_det) begin
        st <= T_ADDR;
        cnt <= '0;
        ours <= 1'b0;
        nbytes <= '0;
        txsh <= '1;
      end else if (stop_det) begin
        st <= T_IDLE;
        txsh <= '1;
        if (ours && !rw && nbytes == 2'd1) begin
          cmd_save <= (last_byte == SAVE_CODE);
          cmd_reload <= (last_byte == RELOAD_CODE);
        end
        ours <= 1'b0;
      end else begin
        case (st)
          T_ADDR: begin
            if (scl_rise && cnt != 4'd8) begin
              rxsh <= {rxsh[6:0], sda_s};
              cnt <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              if (rxsh[7:1] == DEV_ADDR && !busy) begin
                st <= T_ACK;
                rw <= rxsh[0];
                ours <= 1'b1;
              end else begin
                st <= T_IDLE;
              end
            end
          end
          T_ACK: begin
            if (scl_fall) begin
              cnt <= '0;
              if (rw) begin
                txsh <= rd_data;
                ptr <= ptr + 8'd1;
                st <= T_RD;
              end else begin
                st <= T_WR;
              end
            end
          end
          T_WR: begin
            if (scl_rise && cnt != 4'd8) begin
              rxsh <= {rxsh[6:0], sda_s};
              cnt <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              st <= T_ACK;
              last_byte <= rxsh;
              if (nbytes != 2'd3) nbytes <= nbytes + 2'd1;
              if (nbytes == 2'd0) begin
                ptr <= rxsh;
              end else begin
                wr_en <= in_bank;
                wr_addr <= ptr;
                wr_data <= rxsh;
                ptr <= ptr + 8'd1;
              end
            end
          end
          T_RD: begin
            if (scl_fall) begin
              if (cnt == 4'd7) begin
                st <= T_MACK;
                txsh <= '1;
              end else begin
                txsh <= {txsh[6:0], 1'b1};
                cnt <= cnt + 4'd1;
              end
            end
          end
          T_MACK: begin
            if (scl_rise) begin
              mnack <= sda_s;
            end else if (scl_fall) begin
              if (mnack) begin
                st <= T_IDLE;
              end else begin
                txsh <= rd_data;
                ptr <= ptr + 8'd1;
                cnt <= '0;
                st <= T_RD;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R7
  addr_ack_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == T_ACK && $past(st) == T_ADDR) |-> !$past(busy));

  // R2
  wr_from_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ($past(st) == T_WR));
endmodule

// File: rtl/nv_copy_seq.sv
module nv_copy_seq
  import cfg_i2c_pkg::*;
#(
  parameter int NUM_REGS = 16,
  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_save,
  input  logic             cmd_reload,
  input  logic [7:0]       save_data,
  input  logic             nv_ready,
  input  logic             nv_rvalid,
  input  logic [7:0]       nv_rdata,
  output logic             nv_valid,
  output logic             nv_write,
  output logic [IDX_W-1:0] nv_addr,
  output logic [7:0]       nv_wdata,
  output logic             busy,
  output logic             reloading,
  output logic             load_en,
  output logic [IDX_W-1:0] idx,
  output logic [7:0]       load_data
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_REGS - 1);
  nv_state_e st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= N_RLD_REQ;
      idx <= '0;
    end else begin
      case (st)
        N_IDLE: begin
          if (cmd_save) begin
            st <= N_SAVE;
            idx <= '0;
          end else if (cmd_reload) begin
            st <= N_RLD_REQ;
            idx <= '0;
          end
        end
        N_SAVE: begin
          if (nv_ready) begin
            if (idx == LAST) st <= N_IDLE;
            else idx <= idx + 1'b1;
          end
        end
        N_RLD_REQ: if (nv_ready) st <= N_RLD_WAIT;
        N_RLD_WAIT: begin
          if (nv_rvalid) begin
            if (idx == LAST) begin
              st <= N_IDLE;
            end else begin
              idx <= idx + 1'b1;
              st <= N_RLD_REQ;
            end
          end
        end
        default: st <= N_IDLE;
      endcase
    end
  end

  assign nv_valid  = (st == N_SAVE) || (st == N_RLD_REQ);
  assign nv_write  = (st == N_SAVE);
  assign nv_addr   = idx;
  assign nv_wdata  = save_data;
  assign busy      = (st != N_IDLE);
  assign reloading = (st == N_RLD_REQ) || (st == N_RLD_WAIT);
  assign load_en   = (st == N_RLD_WAIT) && nv_rvalid;
  assign load_data = nv_rdata;

  // R10
  nv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nv_valid && !nv_ready) |=> (nv_valid && $stable(nv_addr) && $stable(nv_write) && $stable(nv_wdata)));
endmodule

// File: rtl/cfg_i2c_slave.sv
module cfg_i2c_slave
  import cfg_i2c_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int SYNC_STAGES = 2,
  parameter logic [6:0] DEV_ADDR = DEV_ADDR_DEF,
  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       scl_i,
  input  logic                       sda_i,
  output logic                       sda_oe,
  output logic                       nv_valid,
  input  logic                       nv_ready,
  output logic                       nv_write,
  output logic [IDX_W-1:0]           nv_addr,
  output logic [7:0]                 nv_wdata,
  input  logic                       nv_rvalid,
  input  logic [7:0]                 nv_rdata,
  output logic [NUM_REGS*BYTE_W-1:0] cfg_q,
  output logic                       out_disable
);
  logic sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [7:0] ptr, wr_addr, wr_data, rd_data, save_data, load_data;
  logic wr_en, cmd_save, cmd_reload, busy, reloading, load_en;
  logic [IDX_W-1:0] seq_idx;
  logic ptr_in_bank;

  i2c_line_cond #(.STAGES(SYNC_STAGES)) u_line (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_target_fsm #(.NUM_REGS(NUM_REGS), .DEV_ADDR(DEV_ADDR)) u_fsm (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .busy(busy), .rd_data(rd_data), .ptr(ptr), .sda_oe(sda_oe),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cmd_save(cmd_save), .cmd_reload(cmd_reload)
  );

  nv_copy_seq #(.NUM_REGS(NUM_REGS)) u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_save(cmd_save), .cmd_reload(cmd_reload),
    .save_data(save_data), .nv_ready(nv_ready), .nv_rvalid(nv_rvalid),
    .nv_rdata(nv_rdata), .nv_valid(nv_valid), .nv_write(nv_write),
    .nv_addr(nv_addr), .nv_wdata(nv_wdata), .busy(busy),
    .reloading(reloading), .load_en(load_en), .idx(seq_idx),
    .load_data(load_data)
  );

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic [7:0] r;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) r <= '0;
      else if (load_en && seq_idx == IDX_W'(g)) r <= load_data;
      else if (wr_en && wr_addr == 8'(g)) r <= wr_data;
    end
    assign cfg_q[g*BYTE_W +: BYTE_W] = r;
  end

  assign ptr_in_bank = ({1'b0, ptr} < 9'(NUM_REGS));
  assign rd_data     = ptr_in_bank ? cfg_q[ptr[IDX_W-1:0]*BYTE_W +: BYTE_W] : '0;
  assign save_data   = cfg_q[seq_idx*BYTE_W +: BYTE_W];
  assign out_disable = reloading;

  // R8
  no_cfg_write_in_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_disable |-> !wr_en);

  // R5
  save_starts_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_save |=> (nv_valid && nv_write && nv_addr == '0));

  // R4
  wr_in_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ({1'b0, wr_addr} < 9'(NUM_REGS)));

  // R7
  no_bus_write_while_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && load_en));
endmodule

// File: tb/cfg_i2c_slave_bench.sv
`timescale 1ns/1ps
module cfg_i2c_slave_bench;
  localparam int N = 16;
  localparam int H = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic m_scl = 1'b1, m_sda = 1'b1;
  logic sda_oe, sda_line;
  logic nv_valid, nv_write, out_disable;
  logic nv_ready = 1'b0, nv_rvalid = 1'b0;
  logic [3:0] nv_addr;
  logic [7:0] nv_wdata;
  logic [7:0] nv_rdata = 8'h00;
  logic [N*8-1:0] cfg_q;

  assign sda_line = m_sda & ~sda_oe;

  cfg_i2c_slave u_cfg_i2c_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .nv_valid(nv_valid), .nv_ready(nv_ready), .nv_write(nv_write),
    .nv_addr(nv_addr), .nv_wdata(nv_wdata), .nv_rvalid(nv_rvalid),
    .nv_rdata(nv_rdata), .cfg_q(cfg_q), .out_disable(out_disable)
  );

  int checks = 0, errors = 0;
  int nv_wr_cnt = 0;
  int rcnt = 0;
  logic [7:0] rdat;
  logic nv_stall = 1'b1;
  logic [7:0] exp_regs [N];
  logic [7:0] nv_mem [N];
  logic [7:0] saved [N];
  logic [7:0] wbuf [8];
  logic [7:0] rbuf [8];

  function automatic logic [7:0] exp_rd(int p);
    return (p < N) ? exp_regs[p] : 8'h00;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic chk_bank(input string req);
    for (int i = 0; i < N; i++) chk(req, 32'(cfg_q[i*8 +: 8]), 32'(exp_regs[i]));
  endtask

  // store model: decisions taken at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      nv_rvalid = 1'b0;
      if (rcnt > 0) begin
        rcnt--;
        if (rcnt == 0) begin
          nv_rvalid = 1'b1;
          nv_rdata = rdat;
        end
      end
      nv_ready = !nv_stall && ($urandom_range(0, 3) != 0);
      if (nv_valid && nv_ready) begin
        if (nv_write) begin
          nv_mem[nv_addr] = nv_wdata;
          nv_wr_cnt++;
        end else begin
          rdat = nv_mem[nv_addr];
          rcnt = 3;
        end
      end
    end
  end

  task automatic bit_h();
    repeat (H) @(negedge clk);
  endtask

  task automatic i2c_start();
    m_sda = 1'b1; bit_h();
    m_scl = 1'b1; bit_h();
    m_sda = 1'b0; bit_h();
    m_scl = 1'b0; bit_h();
  endtask

  task automatic i2c_stop();
    m_sda = 1'b0; bit_h();
    m_scl = 1'b1; bit_h();
    m_sda = 1'b1; bit_h();
    bit_h();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; bit_h();
      m_scl = 1'b1; bit_h();
      m_scl = 1'b0;
    end
    m_sda = 1'b1; bit_h();
    m_scl = 1'b1;
    repeat (H/2) @(negedge clk);
    ack = ~sda_line;
    repeat (H/2) @(negedge clk);
    m_scl = 1'b0; bit_h();
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      bit_h();
      m_scl = 1'b1;
      repeat (H/2) @(negedge clk);
      b[i] = sda_line;
      repeat (H/2) @(negedge clk);
      m_scl = 1'b0;
    end
    m_sda = mack ? 1'b0 : 1'b1; bit_h();
    m_scl = 1'b1; bit_h();
    m_scl = 1'b0; bit_h();
    m_sda = 1'b1;
  endtask

  task automatic wr_frame(input logic [7:0] p, input int n, output logic ack_a);
    logic a;
    i2c_start();
    send_byte(8'hD4, ack_a);
    if (ack_a) begin
      send_byte(p, a);
      for (int i = 0; i < n; i++) send_byte(wbuf[i], a);
    end
    i2c_stop();
  endtask

  task automatic model_write(input int p, input int n);
    for (int i = 0; i < n; i++) if (p + i < N) exp_regs[p+i] = wbuf[i];
  endtask

  task automatic rd_cont(input int n);
    logic a;
    i2c_start();
    send_byte(8'hD5, a);
    for (int i = 0; i < n; i++) recv_byte(i != n - 1, rbuf[i]);
    i2c_stop();
  endtask

  task automatic rd_frame(input logic [7:0] p, input logic use_rs, input int n);
    logic a;
    i2c_start();
    send_byte(8'hD4, a);
    send_byte(p, a);
    if (!use_rs) i2c_stop();
    rd_cont(n);
  endtask

  task automatic addr_probe(output logic ack);
    i2c_start();
    send_byte(8'hD4, ack);
    i2c_stop();
  endtask

  task automatic cmd_frame(input logic [7:0] code, output logic ack);
    logic a;
    i2c_start();
    send_byte(8'hD4, ack);
    send_byte(code, a);
    i2c_stop();
  endtask

  initial begin
    logic a;
    int base;
    void'($urandom(32'd2024));
    for (int i = 0; i < N; i++) begin
      nv_mem[i] = 8'(i * 37 + 11);
      exp_regs[i] = nv_mem[i];
    end
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R8 out_disable during power-up reload", 32'(out_disable), 1);
    addr_probe(a);
    chk("R8 address refused before power-up reload ends", 32'(a), 0);
    nv_stall = 1'b0;
    repeat (300) @(negedge clk);
    chk("R8 out_disable low after reload", 32'(out_disable), 0);
    chk_bank("R8 R6 power-up reload contents");

    // R1 foreign address
    i2c_start();
    send_byte(8'hD6, a);
    chk("R1 foreign address not acknowledged", 32'(a), 0);
    send_byte(8'h00, a);
    send_byte(8'hFF, a);
    i2c_stop();
    chk_bank("R1 foreign frame changes nothing");

    // R2 R11 directed write
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
    wr_frame(8'd3, 3, a);
    chk("R1 own address acknowledged", 32'(a), 1);
    model_write(3, 3);
    chk_bank("R2 R11 directed burst write");

    // R3 reads
    rd_frame(8'd3, 1'b1, 3);
    for (int i = 0; i < 3; i++) chk("R3 read after repeated START", 32'(rbuf[i]), 32'(exp_rd(3 + i)));
    rd_cont(2);
    for (int i = 0; i < 2; i++) chk("R3 pointer carries across frames", 32'(rbuf[i]), 32'(exp_rd(6 + i)));
    rd_frame(8'd2, 1'b0, 2);
    for (int i = 0; i < 2; i++) chk("R3 read after STOP and START", 32'(rbuf[i]), 32'(exp_rd(2 + i)));

    // R4 beyond the bank
    wbuf[0] = 8'hA1; wbuf[1] = 8'hB2; wbuf[2] = 8'hC3; wbuf[3] = 8'hD4;
    wr_frame(8'd14, 4, a);
    model_write(14, 4);
    chk_bank("R4 write crossing the end of the bank");
    rd_frame(8'd15, 1'b1, 3);
    for (int i = 0; i < 3; i++) chk("R4 read crossing the end of the bank", 32'(rbuf[i]), 32'(exp_rd(15 + i)));
    rd_frame(8'd200, 1'b1, 1);
    chk("R4 far pointer reads zero", 32'(rbuf[0]), 0);

    // random bursts
    for (int t = 0; t < 25; t++) begin
      int p, n;
      p = $urandom_range(0, 19);
      n = $urandom_range(1, 4);
      for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
      wr_frame(8'(p), n, a);
      model_write(p, n);
      p = $urandom_range(0, 19);
      n = $urandom_range(1, 4);
      rd_frame(8'(p), 1'($urandom_range(0, 1)), n);
      for (int i = 0; i < n; i++) chk("R2 R3 random burst read-back", 32'(rbuf[i]), 32'(exp_rd(p + i)));
    end
    chk_bank("R2 R11 bank after random bursts");

    // R5 R7 save with stalled store
    nv_stall = 1'b1;
    cmd_frame(8'hA5, a);
    chk("R5 save frame acknowledged", 32'(a), 1);
    repeat (5) @(negedge clk);
    chk("R8 out_disable stays low during save", 32'(out_disable), 0);
    addr_probe(a);
    chk("R7 address refused during save", 32'(a), 0);
    base = nv_wr_cnt;
    nv_stall = 1'b0;
    repeat (300) @(negedge clk);
    chk("R10 one store write per register", 32'(nv_wr_cnt - base), N);
    for (int i = 0; i < N; i++) chk("R5 store holds saved bank", 32'(nv_mem[i]), 32'(exp_regs[i]));
    addr_probe(a);
    chk("R7 address acknowledged after save", 32'(a), 1);
    for (int i = 0; i < N; i++) saved[i] = exp_regs[i];

    // change the bank so a stray save would be visible
    for (int i = 0; i < 4; i++) wbuf[i] = 8'(8'h5C ^ saved[i] ^ 8'hFF);
    wr_frame(8'd0, 4, a);
    model_write(0, 4);
    chk_bank("R2 overwrite before command tests");

    // R9 command byte that is not alone
    base = nv_wr_cnt;
    wbuf[0] = 8'h11;
    wr_frame(8'hA5, 1, a);
    addr_probe(a);
    chk("R9 no busy period after two-byte frame", 32'(a), 1);
    repeat (300) @(negedge clk);
    chk("R9 no store writes after two-byte frame", 32'(nv_wr_cnt - base), 0);
    chk_bank("R9 R4 bank unchanged by out-of-bank write");

    // R6 reload with stalled store
    nv_stall = 1'b1;
    cmd_frame(8'hC3, a);
    repeat (5) @(negedge clk);
    chk("R8 out_disable during commanded reload", 32'(out_disable), 1);
    addr_probe(a);
    chk("R7 address refused during reload", 32'(a), 0);
    nv_stall = 1'b0;
    repeat (300) @(negedge clk);
    chk("R8 out_disable low after commanded reload", 32'(out_disable), 0);
    for (int i = 0; i < N; i++) exp_regs[i] = saved[i];
    chk_bank("R6 reload restores saved bank");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(negedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule